// File: doc/BRIEF.md
# Wake-up debounce and shutdown controller

This block runs from a 32768 Hz slow clock and keeps a chip in a low-power shutdown state until something asks it to wake. There are two kinds of wake source: a set of external wake-up pins, and two timer requests, one from a real-time clock and one from a real-time timer. Each pin can be enabled on its own and wakes on either a high or a low level. The pin's level first passes through a two-flop synchronizer. It must then hold its active level for a programmable number of slow-clock cycles before it counts.

Software sees four word addresses. A write to the command address puts the block into shutdown. A mode word selects the debounce length and enables the two timer sources. A pin word holds the per-pin enables and levels. A status word reports which sources caused the most recent wake-up, and a read of it clears it. When the block leaves shutdown, it raises `wake_event` for one slow-clock cycle. Data words are `2*NPIN` bits wide.

Top module: `wkc_top`

## Requirements
- R1: After reset the block is awake (`in_shutdown`=0) and `wake_event` is 0. The mode, pin and status words all read 0.
- R2: Mode word (address 1): bits [2:0] hold the debounce code, bit 3 enables the RTC wake source and bit 4 enables the RTT wake source. Pin word (address 2): bits [NPIN-1:0] are the pin enables and bits [2*NPIN-1:NPIN] are the pin levels. Both words read back what was written.
- R3: A write to address 0 with data bit 0 set, while no enabled source is active, makes `in_shutdown` 1 from the next cycle.
- R4: A pin whose enable bit is 0 never wakes the block and never sets its status flag.
- R5: A pin whose level bit is 1 is active when high. A pin whose level bit is 0 is active when low.
- R6: Debounce codes 0 to 5 select 0, 3, 32, 512, 4096 and 32768 cycles. A pin that enters its active level just after a clock edge, while the block is in shutdown, makes the block leave shutdown on exactly the (N+3)th following edge, where N is the selected number of cycles.
- R7: Debounce codes 6 and 7 behave the same as code 5 (32768 cycles).
- R8: A pin that returns to its inactive level before its count completes restarts its count from zero.
- R9: The RTC and RTT requests wake the block only when their mode enables are set. They report in status bits NPIN (RTC) and NPIN+1 (RTT), and pin i reports in status bit i.
- R10: Status flags are set only in shutdown, or by a rejected shutdown command. They stay set until the status word (address 3) is read, and that read returns the flags and then clears them.
- R11: A shutdown command issued while an enabled source is active leaves the block awake and records the active sources in status.
- R12: `wake_event` is 1 for exactly one cycle, in the first cycle after the block leaves shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | 32768 Hz slow clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_wake | input | NPIN | External wake-up pins, asynchronous |
| rtc_wake_req | input | 1 | RTC wake request, slow-clock synchronous |
| rtt_wake_req | input | 1 | RTT wake request, slow-clock synchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Word address: 0 command, 1 mode, 2 pins, 3 status |
| reg_wdata | input | 2*NPIN | Write data |
| reg_rdata | output | 2*NPIN | Read data, combinational from the address |
| in_shutdown | output | 1 | High while in the shutdown state |
| wake_event | output | 1 | One-cycle pulse on leaving shutdown |

## Verification
The assertions assume three things about the inputs. The timer requests already change in step with the slow clock. A write and a read are never asserted in the same cycle. Reset is released only while the register strobes are low. Only the pins may be asynchronous, and the synchronizer absorbs them. The stimulus changes every input, pins included, half a period away from the active edge. It issues one register access at a time and holds each timer request for whole cycles, so it stays within these assumptions.

// File: rtl/wkc_pkg.sv
package wkc_pkg;

    localparam int DBC_W = 16;

    localparam logic [1:0] ADDR_CMD  = 2'd0;
    localparam logic [1:0] ADDR_MODE = 2'd1;
    localparam logic [1:0] ADDR_PINS = 2'd2;
    localparam logic [1:0] ADDR_STAT = 2'd3;

    localparam int MODE_RTC_BIT = 3;
    localparam int MODE_RTT_BIT = 4;

    typedef enum logic {
        ST_AWAKE = 1'b0,
        ST_SHDN  = 1'b1
    } pwr_st_t;

    // debounce length in slow-clock cycles for a 3-bit code; 6 and 7 saturate
    function automatic logic [DBC_W-1:0] dbc_cycles(input logic [2:0] code);
        logic [DBC_W-1:0] n;
        case (code)
            3'd0:    n = DBC_W'(0);
            3'd1:    n = DBC_W'(3);
            3'd2:    n = DBC_W'(32);
            3'd3:    n = DBC_W'(512);
            3'd4:    n = DBC_W'(4096);
            default: n = DBC_W'(32768);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/wkc_sync.sv
module wkc_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t r_q, r_d;

    always_comb begin
        r_d    = r_q;
        r_d.s1 = din;
        r_d.s2 = r_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign dout = r_q.s2;

    // second stage always follows the first one cycle later
    p_sync_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (r_q.s2 == $past(r_q.s1)));

endmodule

// File: rtl/wkc_debounce.sv
module wkc_debounce
    import wkc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl,
    input  logic             pol,
    input  logic [DBC_W-1:0] limit,
    output logic             active
);

    typedef struct packed {
        logic [DBC_W-1:0] cnt;
    } dbc_t;

    dbc_t r_q, r_d;
    logic raw;

    always_comb begin
        raw = (lvl == pol);
        r_d = r_q;
        if (!raw)
            r_d.cnt = '0;
        else if (r_q.cnt < limit)
            r_d.cnt = r_q.cnt + DBC_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign active = raw && (r_q.cnt >= limit);

    // a debounced pin was already at its level in the previous cycle
    p_hold_before_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (limit != '0 && active) |-> $past(raw));

    // an inactive level always restarts the count
    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !raw |=> (r_q.cnt == '0));

endmodule

// File: rtl/wkc_ctrl.sv
module wkc_ctrl
    import wkc_pkg::*;
#(
    parameter int NSRC = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src,
    input  logic            cmd,
    input  logic            stat_clr,
    output logic            shdn,
    output logic            wake_pulse,
    output logic [NSRC-1:0] status
);

    typedef struct packed {
        pwr_st_t         st;
        logic [NSRC-1:0] stat;
        logic            pulse;
    } ctrl_t;

    ctrl_t r_q, r_d;
    logic  any_src;

    always_comb begin
        any_src = |src;
        r_d       = r_q;
        r_d.pulse = 1'b0;
        if (stat_clr) r_d.stat = '0;
        if (r_q.st == ST_AWAKE) begin
            if (cmd) begin
                if (any_src) r_d.stat = r_d.stat | src;
                else         r_d.st   = ST_SHDN;
            end
        end else begin
            if (any_src) begin
                r_d.stat  = r_d.stat | src;
                r_d.st    = ST_AWAKE;
                r_d.pulse = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_AWAKE, stat: '0, pulse: 1'b0};
        else        r_q <= r_d;
    end

    assign shdn       = (r_q.st == ST_SHDN);
    assign wake_pulse = r_q.pulse;
    assign status     = r_q.stat;

    p_pulse_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.pulse |=> !r_q.pulse);

    p_pulse_on_exit_r12: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.pulse |-> ($past(r_q.st) == ST_SHDN && r_q.st == ST_AWAKE));

    p_flags_only_shdn_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|(r_q.stat & ~$past(r_q.stat))) |-> ($past(r_q.st) == ST_SHDN || $past(cmd)));

    p_reject_stays_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_AWAKE && cmd && any_src) |=> (r_q.st == ST_AWAKE));

    p_shdn_needs_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shdn) |-> $past(cmd));

endmodule

// File: rtl/wkc_top.sv
module wkc_top
    import wkc_pkg::*;
#(
    parameter int NPIN = 4,
    localparam int REG_W = 2 * NPIN,
    localparam int NSRC = NPIN + 2
) (
    input  logic             clk_slow,
    input  logic             rst_n,
    input  logic [NPIN-1:0]  pin_wake,
    input  logic             rtc_wake_req,
    input  logic             rtt_wake_req,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             in_shutdown,
    output logic             wake_event
);

    typedef struct packed {
        logic [2:0]      sel;
        logic            rtc_en;
        logic            rtt_en;
        logic [NPIN-1:0] en;
        logic [NPIN-1:0] pol;
    } cfg_t;

    cfg_t r_q, r_d;

    logic [NPIN-1:0]  pin_sync;
    logic [NPIN-1:0]  pin_act;
    logic [DBC_W-1:0] limit;
    logic [NSRC-1:0]  src;
    logic [NSRC-1:0]  stat_vec;
    logic             cmd;
    logic             stat_clr;

    initial begin
        if (NPIN < 3 || NPIN > 16) $error("wkc_top: NPIN out of range");
    end

    always_comb begin
        r_d = r_q;
        if (reg_wr) begin
            case (reg_addr)
                ADDR_MODE: begin
                    r_d.sel    = reg_wdata[2:0];
                    r_d.rtc_en = reg_wdata[MODE_RTC_BIT];
                    r_d.rtt_en = reg_wdata[MODE_RTT_BIT];
                end
                ADDR_PINS: begin
                    r_d.en  = reg_wdata[NPIN-1:0];
                    r_d.pol = reg_wdata[REG_W-1:NPIN];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_slow or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cmd      = reg_wr && (reg_addr == ADDR_CMD) && reg_wdata[0];
    assign stat_clr = reg_rd && (reg_addr == ADDR_STAT);
    assign limit    = dbc_cycles(r_q.sel);

    wkc_sync #(.W(NPIN)) u_sync (
        .clk   (clk_slow),
        .rst_n (rst_n),
        .din   (pin_wake),
        .dout  (pin_sync)
    );

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        wkc_debounce u_dbc (
            .clk    (clk_slow),
            .rst_n  (rst_n),
            .lvl    (pin_sync[i]),
            .pol    (r_q.pol[i]),
            .limit  (limit),
            .active (pin_act[i])
        );
    end

    assign src = {rtt_wake_req & r_q.rtt_en, rtc_wake_req & r_q.rtc_en, pin_act & r_q.en};

    wkc_ctrl #(.NSRC(NSRC)) u_ctrl (
        .clk        (clk_slow),
        .rst_n      (rst_n),
        .src        (src),
        .cmd        (cmd),
        .stat_clr   (stat_clr),
        .shdn       (in_shutdown),
        .wake_pulse (wake_event),
        .status     (stat_vec)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_MODE: begin
                reg_rdata[2:0]          = r_q.sel;
                reg_rdata[MODE_RTC_BIT] = r_q.rtc_en;
                reg_rdata[MODE_RTT_BIT] = r_q.rtt_en;
            end
            ADDR_PINS: reg_rdata = {r_q.pol, r_q.en};
            ADDR_STAT: reg_rdata[NSRC-1:0] = stat_vec;
            default: ;
        endcase
    end

    p_disabled_pin_no_flag_r4: assert property (@(posedge clk_slow) disable iff (!rst_n)
        ((stat_vec[NPIN-1:0] & ~$past(stat_vec[NPIN-1:0]) & ~$past(r_q.en)) == '0));

    p_timer_gated_r9: assert property (@(posedge clk_slow) disable iff (!rst_n)
        (stat_vec[NPIN] && !$past(stat_vec[NPIN])) |-> $past(r_q.rtc_en && rtc_wake_req));

    p_no_rdwr_clash_r2: assert property (@(posedge clk_slow) disable iff (!rst_n)
        !(reg_wr && reg_rd));

endmodule

// File: tb/wkc_top_bench.sv
module wkc_top_bench;

    localparam int NPIN  = 4;
    localparam int REG_W = 2 * NPIN;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NPIN-1:0]  pin_wake = '0;
    logic             rtc_req = 1'b0;
    logic             rtt_req = 1'b0;
    logic             reg_wr = 1'b0;
    logic             reg_rd = 1'b0;
    logic [1:0]       reg_addr = '0;
    logic [REG_W-1:0] reg_wdata = '0;
    logic [REG_W-1:0] reg_rdata;
    logic             in_shutdown;
    logic             wake_event;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    wkc_top #(.NPIN(NPIN)) u_wkc_top (
        .clk_slow     (clk),
        .rst_n        (rst_n),
        .pin_wake     (pin_wake),
        .rtc_wake_req (rtc_req),
        .rtt_wake_req (rtt_req),
        .reg_wr       (reg_wr),
        .reg_rd       (reg_rd),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .in_shutdown  (in_shutdown),
        .wake_event   (wake_event)
    );

    function automatic int dbc_len(input int code);
        case (code)
            0: return 0;
            1: return 3;
            2: return 32;
            3: return 512;
            4: return 4096;
            default: return 32768;
        endcase
    endfunction

    function automatic logic [NPIN-1:0] exp_active(input logic [NPIN-1:0] en,
                                                   input logic [NPIN-1:0] pol,
                                                   input logic [NPIN-1:0] lvl);
        return en & ~(lvl ^ pol);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [REG_W-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [REG_W-1:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic dbc_case(input int code, input string req);
        logic [REG_W-1:0] d;
        int n;
        n = dbc_len(code);
        pin_wake = '0;
        wr(2'd2, {4'b0001, 4'b0001});
        wr(2'd1, REG_W'(code));
        wait_n(4);
        rd(2'd3, d);
        wr(2'd0, 8'h01);
        check({req, " enters shutdown"}, in_shutdown, 1);
        pin_wake[0] = 1'b1;
        wait_n(n + 2);
        check({req, " still asleep at N+2"}, in_shutdown, 0 + 1);
        wait_n(1);
        check({req, " awake at N+3"}, in_shutdown, 0);
        check({req, " wake pulse"}, wake_event, 1);
        pin_wake = '0;
        rd(2'd3, d);
        check({req, " status pin0"}, d, 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [REG_W-1:0] d;
        logic [NPIN-1:0] en, pol, p, p2, a, a2;
        void'($urandom(32'd4711));

        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);

        // R1 reset state
        check("R1 in_shutdown", in_shutdown, 0);
        check("R1 wake_event", wake_event, 0);
        rd(2'd1, d); check("R1 mode", d, 0);
        rd(2'd2, d); check("R1 pins", d, 0);
        rd(2'd3, d); check("R1 status", d, 0);

        // R2 readback
        wr(2'd1, 8'h1D); rd(2'd1, d); check("R2 mode readback", d, 8'h1D);
        wr(2'd2, 8'hA5); rd(2'd2, d); check("R2 pins readback", d, 8'hA5);
        wr(2'd1, 8'h00); wr(2'd2, 8'h00);

        // R3 R4 R5 R10 R11 R12 random with code 0
        for (int it = 0; it < 40; it++) begin
            en  = NPIN'($urandom);
            pol = NPIN'($urandom);
            p   = NPIN'($urandom);
            wr(2'd2, {pol, en});
            pin_wake = p;
            wait_n(4);
            rd(2'd3, d);
            rd(2'd3, d);
            check("R10 no flag while awake", d, 0);
            a = exp_active(en, pol, p);
            wr(2'd0, 8'h01);
            if (a != '0) begin
                check("R11 reject keeps awake", in_shutdown, 0);
                rd(2'd3, d);
                check("R11 rejected sources recorded", d, a);
            end else begin
                check("R3 shutdown entered", in_shutdown, 1);
                p2 = NPIN'($urandom);
                a2 = exp_active(en, pol, p2);
                pin_wake = p2;
                wait_n(2);
                check("R5 not yet awake", in_shutdown, 1);
                wait_n(1);
                if (a2 != '0) begin
                    check("R5 wake on active level", in_shutdown, 0);
                    check("R12 pulse high", wake_event, 1);
                    wait_n(1);
                    check("R12 pulse one cycle", wake_event, 0);
                    rd(2'd3, d);
                    check("R4 status only enabled active pins", d, a2);
                end else begin
                    check("R4 disabled or inactive pins no wake", in_shutdown, 1);
                    rtc_req = 1'b1;
                    wr(2'd1, 8'h08);
                    wait_n(1);
                    check("R9 rtc wake", in_shutdown, 0);
                    rtc_req = 1'b0;
                    wr(2'd1, 8'h00);
                    rd(2'd3, d);
                    check("R9 rtc flag bit NPIN", d, 8'h10);
                end
            end
        end

        // R6 R7 debounce lengths
        dbc_case(1, "R6 code1");
        dbc_case(2, "R6 code2");
        dbc_case(3, "R6 code3");
        dbc_case(4, "R6 code4");
        dbc_case(5, "R6 code5");
        dbc_case(6, "R7 code6");
        dbc_case(7, "R7 code7");

        // R8 restart of the count (code 1, N=3)
        pin_wake = '0;
        wr(2'd2, {4'b0001, 4'b0001});
        wr(2'd1, 8'h01);
        wait_n(4);
        rd(2'd3, d);
        wr(2'd0, 8'h01);
        pin_wake[0] = 1'b1;
        wait_n(3);
        pin_wake[0] = 1'b0;
        wait_n(3);
        check("R8 short pulse ignored", in_shutdown, 1);
        pin_wake[0] = 1'b1;
        wait_n(5);
        check("R8 restart still asleep at N+2", in_shutdown, 1);
        wait_n(1);
        check("R8 wake at N+3 after restart", in_shutdown, 0);
        pin_wake = '0;
        rd(2'd3, d);

        // R9 R10 RTT gated by enable, status held until read
        wr(2'd2, 8'h00);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h01);
        check("R9 shutdown for rtt", in_shutdown, 1);
        rtt_req = 1'b1;
        wait_n(3);
        check("R9 rtt ignored when disabled", in_shutdown, 1);
        wr(2'd1, 8'h10);
        wait_n(1);
        check("R9 rtt wake when enabled", in_shutdown, 0);
        rtt_req = 1'b0;
        wait_n(5);
        rd(2'd3, d);
        check("R10 rtt flag held until read", d, 8'h20);
        rd(2'd3, d);
        check("R10 read clears", d, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule